// File: doc/BRIEF.md
# Counter-Ramp Conversion Sequencer

This block is the digital controller of a staircase analog-to-digital converter. A start request resets an up-counter to zero. The counter value goes straight out as the code for an external DAC. An external comparator reports whether the analog input still sits above the DAC level. While it does, the counter climbs one code at a time. When it does not, the count is captured as the conversion result and a done flag is raised.

After every code change the sequencer waits a programmable number of clocks for the DAC to settle, then reads the comparator once. A search therefore ends on the first code at or above the input level. Conversion time grows linearly with that level. The worst case is one full sweep through the code range.

If the counter reaches full scale while the comparator is still high, the sequencer stops there. It captures full scale as the result and raises an overflow flag. Requests that arrive during a search are ignored. The result register holds the last completed value until the next search completes.

Top module: `rampAdcSeq`

## Requirements
- R1: While reset (rstN low) is applied and after its release, dacCode and resultCode are zero and doneFlag and overflowFlag are low.
- R2: A startReq sampled high while no search is running sets dacCode to zero on that clock edge.
- R3: During a search, each code is held for SETTLE_CYC+1 clock cycles. The next code is always exactly one higher.
- R4: cmpHigh (1 = analog input above DAC level) is read only on the last cycle of each code's hold. The first low reading stores the current code in resultCode and raises doneFlag on the same edge. For an input level V not above full scale, the search lasts (V+1)*(SETTLE_CYC+1) cycles after the start edge.
- R5: If cmpHigh is high when the full-scale code (all ones) is read, the search stops. resultCode becomes all ones, and doneFlag and overflowFlag rise together.
- R6: An input level exactly equal to full scale yields resultCode all ones with overflowFlag low.
- R7: A startReq arriving while a search is running has no effect on dacCode, resultCode or the completion time.
- R8: doneFlag and overflowFlag keep their value until the next accepted startReq. That start clears both on its clock edge.
- R9: resultCode changes only on the edge where doneFlag rises. During a new search it keeps the previous result.
- R10: A low cmpHigh during a DAC settling cycle (any cycle of a code's hold other than the last) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Begin a conversion (taken only when idle or done) |
| cmpHigh | input | 1 | Comparator: 1 while analog input exceeds DAC level |
| dacCode | output | CODE_W | Code driven to the external DAC |
| resultCode | output | CODE_W | Last completed conversion result |
| doneFlag | output | 1 | High from completion until the next accepted start |
| overflowFlag | output | 1 | High when the input exceeded full scale |

## Verification
The bench builds the sequencer with a 4-bit code and two settling cycles. This makes a full sweep only 48 cycles long, so every input level from 0 to one step above full scale can be converted. For each level, the bench checks the staircase timing cycle by cycle and the exact completion latency. The over-range level and the exact full-scale level exercise both overflow outcomes. Extra runs inject a mid-search start request and a comparator glitch during a settling cycle.

// File: rtl/rampAdcPkg.sv
package rampAdcPkg;

  typedef enum logic [1:0] {
    CONV_IDLE     = 2'd0,
    CONV_RUN      = 2'd1,
    CONV_FINISHED = 2'd2
  } convState_e;

  // Strobes from control to datapath, at most a few active per cycle.
  typedef struct packed {
    logic clrCode;
    logic incCode;
    logic loadSettle;
    logic decSettle;
    logic captureResult;
  } stepStrobes_t;

endpackage

// File: rtl/rampAdcDatapath.sv
module rampAdcDatapath
  import rampAdcPkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepStrobes_t      strobes,
  output logic [CODE_W-1:0] codeQ,
  output logic [CODE_W-1:0] resultQ,
  output logic              codeAtMax,
  output logic              settleDone
);

  localparam int SETTLE_W = (SETTLE_CYC > 0) ? $clog2(SETTLE_CYC + 1) : 1;

  // Ramp counter feeding the DAC.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= '0;
    end else if (strobes.clrCode) begin
      codeQ <= '0;
    end else if (strobes.incCode) begin
      codeQ <= codeQ + 1'b1;
    end
  end

  // Result register: loaded only on completion.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
    end else if (strobes.captureResult) begin
      resultQ <= codeQ;
    end
  end

  assign codeAtMax = &codeQ;

  // Settling timer: omitted entirely when no wait is configured.
  generate
    if (SETTLE_CYC == 0) begin : gNoSettle
      logic unusedSettleStrobes;
      assign unusedSettleStrobes = strobes.loadSettle ^ strobes.decSettle;
      assign settleDone = 1'b1;
    end else begin : gSettle
      logic [SETTLE_W-1:0] settleCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          settleCnt <= '0;
        end else if (strobes.loadSettle) begin
          settleCnt <= SETTLE_W'(SETTLE_CYC);
        end else if (strobes.decSettle && settleCnt != '0) begin
          settleCnt <= settleCnt - 1'b1;
        end
      end
      assign settleDone = (settleCnt == '0);
    end
  endgenerate

endmodule

// File: rtl/rampAdcControl.sv
module rampAdcControl
  import rampAdcPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         cmpHigh,
  input  logic         codeAtMax,
  input  logic         settleDone,
  output stepStrobes_t strobes,
  output logic         convBusy,
  output logic         doneFlag,
  output logic         overflowFlag
);

  convState_e state, nextState;
  logic setOvf, clrOvf;

  always_comb begin
    nextState = state;
    strobes   = '0;
    setOvf    = 1'b0;
    clrOvf    = 1'b0;
    unique case (state)
      CONV_IDLE, CONV_FINISHED: begin
        if (startReq) begin
          strobes.clrCode    = 1'b1;
          strobes.loadSettle = 1'b1;
          clrOvf             = 1'b1;
          nextState          = CONV_RUN;
        end
      end
      CONV_RUN: begin
        if (!settleDone) begin
          strobes.decSettle = 1'b1;
        end else if (!cmpHigh) begin
          strobes.captureResult = 1'b1;
          nextState             = CONV_FINISHED;
        end else if (codeAtMax) begin
          strobes.captureResult = 1'b1;
          setOvf                = 1'b1;
          nextState             = CONV_FINISHED;
        end else begin
          strobes.incCode    = 1'b1;
          strobes.loadSettle = 1'b1;
        end
      end
      default: nextState = CONV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= CONV_IDLE;
    end else begin
      state <= nextState;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflowFlag <= 1'b0;
    end else if (clrOvf) begin
      overflowFlag <= 1'b0;
    end else if (setOvf) begin
      overflowFlag <= 1'b1;
    end
  end

  assign convBusy = (state == CONV_RUN);
  assign doneFlag = (state == CONV_FINISHED);

endmodule

// File: rtl/rampAdcSeq.sv
module rampAdcSeq
  import rampAdcPkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              cmpHigh,
  output logic [CODE_W-1:0] dacCode,
  output logic [CODE_W-1:0] resultCode,
  output logic              doneFlag,
  output logic              overflowFlag
);

  stepStrobes_t strobes;
  logic codeAtMax, settleDone, convBusy;

  rampAdcControl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .cmpHigh      (cmpHigh),
    .codeAtMax    (codeAtMax),
    .settleDone   (settleDone),
    .strobes      (strobes),
    .convBusy     (convBusy),
    .doneFlag     (doneFlag),
    .overflowFlag (overflowFlag)
  );

  rampAdcDatapath #(
    .CODE_W     (CODE_W),
    .SETTLE_CYC (SETTLE_CYC)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .codeQ      (dacCode),
    .resultQ    (resultCode),
    .codeAtMax  (codeAtMax),
    .settleDone (settleDone)
  );

endmodule

// File: rtl/rampAdcChecker.sv
module rampAdcChecker #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              cmpHigh,
  input logic [CODE_W-1:0] dacCode,
  input logic [CODE_W-1:0] resultCode,
  input logic              doneFlag,
  input logic              overflowFlag,
  input logic              convBusy
);

  // R2
  code_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReq && !convBusy |=> dacCode == '0);

  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(convBusy) && convBusy && dacCode != $past(dacCode)
      |-> dacCode == CODE_W'($past(dacCode) + 1'b1));

  // R4
  capture_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> resultCode == $past(dacCode));

  // R4
  stop_on_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) && !overflowFlag |-> !$past(cmpHigh));

  // R5
  overflow_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflowFlag) |-> doneFlag && (&resultCode));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    convBusy && startReq && dacCode != '0 |=> dacCode != '0);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && !startReq |=> doneFlag);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(doneFlag) |-> $stable(resultCode));

endmodule

bind rampAdcSeq rampAdcChecker #(.CODE_W(CODE_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .startReq     (startReq),
  .cmpHigh      (cmpHigh),
  .dacCode      (dacCode),
  .resultCode   (resultCode),
  .doneFlag     (doneFlag),
  .overflowFlag (overflowFlag),
  .convBusy     (convBusy)
);

// File: tb/rampAdcSeq_tb_top.sv
`timescale 1ns/1ps
module rampAdcSeq_tb_top;

  localparam int CW   = 4;
  localparam int SC   = 2;
  localparam int PER  = SC + 1;
  localparam int FULL = (1 << CW) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN, startReq, glitchLow, cmpHigh;
  int            vinLevel;
  logic [CW-1:0] dacCode, resultCode;
  logic          doneFlag, overflowFlag;
  int            checks = 0, fails = 0, prevResult = 0;

  // Ideal comparator model with an optional forced-low glitch.
  assign cmpHigh = !glitchLow && (vinLevel > int'(dacCode));

  rampAdcSeq #(.CODE_W(CW), .SETTLE_CYC(SC)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpHigh(cmpHigh),
    .dacCode(dacCode), .resultCode(resultCode),
    .doneFlag(doneFlag), .overflowFlag(overflowFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One conversion; restartAt / glitchAt give the sample index at which to
  // pulse startReq or force the comparator low (0 = never).
  task automatic convert(input int level, input int restartAt, input int glitchAt);
    int expCode, expLat, c, badCode, badExp;
    bit stairOk;
    expCode = (level > FULL) ? FULL : level;
    expLat  = (expCode + 1) * PER;
    @(negedge clk);
    vinLevel = level;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    c = 1;
    check(dacCode == '0, "R2", int'(dacCode), 0);
    check(!doneFlag && !overflowFlag, "R8", int'({doneFlag, overflowFlag}), 0);
    check(int'(resultCode) == prevResult, "R9", int'(resultCode), prevResult);
    stairOk = 1'b1; badCode = 0; badExp = 0;
    while (!doneFlag && c < 4 * expLat + 8) begin
      if (stairOk && int'(dacCode) != (c - 1) / PER) begin
        stairOk = 1'b0;
        badCode = int'(dacCode);
        badExp  = (c - 1) / PER;
      end
      startReq  = (c == restartAt);
      glitchLow = (c == glitchAt);
      @(negedge clk);
      c++;
    end
    startReq  = 1'b0;
    glitchLow = 1'b0;
    check(stairOk, "R3", badCode, badExp);
    check(c - 1 == expLat, "R4", c - 1, expLat);
    check(int'(resultCode) == expCode, "R4", int'(resultCode), expCode);
    check(overflowFlag == (level > FULL), (level > FULL) ? "R5" : "R6",
          int'(overflowFlag), int'(level > FULL));
    repeat (3) @(negedge clk);
    check(doneFlag && overflowFlag == (level > FULL), "R8",
          int'({doneFlag, overflowFlag}), int'({1'b1, level > FULL}));
    check(int'(resultCode) == expCode, "R9", int'(resultCode), expCode);
    prevResult = expCode;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; startReq = 1'b0; glitchLow = 1'b0; vinLevel = 0;
    repeat (3) @(negedge clk);
    // R1: during reset
    check(dacCode == '0 && resultCode == '0 && !doneFlag && !overflowFlag, "R1",
          int'({dacCode, resultCode, doneFlag, overflowFlag}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1: after release
    check(dacCode == '0 && resultCode == '0 && !doneFlag && !overflowFlag, "R1",
          int'({dacCode, resultCode, doneFlag, overflowFlag}), 0);

    // Sweep every level, including full scale (R6) and over-range (R5).
    for (int lvl = 0; lvl <= FULL + 1; lvl++) convert(lvl, 0, 0);
    convert(FULL + 5, 0, 0);
    convert(3, 0, 0);

    // R7: start pulse in the middle of a search
    convert(9, 5, 0);
    check(int'(resultCode) == 9, "R7", int'(resultCode), 9);

    // R10: comparator glitch on a settling cycle (sample 4 is code 1, settle)
    convert(7, 0, 4);
    check(int'(resultCode) == 7 && !overflowFlag, "R10", int'(resultCode), 7);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule